// File: doc/BRIEF.md
# Strobe-Aligned Dual-Clock Sample FIFO

This block carries a stream of samples from a write clock domain into a read clock domain. It does so through a ring of eight entries. Every write-clock cycle stores one sample, and every read-clock cycle presents one sample. The pointers are meant to be placed at known positions, so that several copies of the block in a system produce their output with the same timing. They get there through timing strobes rather than through the reset pin.

The write pointer returns to entry 0 on a rising edge of whichever write-side strobe its select field enables. The read pointer jumps to a programmable offset on a rising edge of a strobe enabled by its own select field. That strobe can be a local output strobe sampled directly in the read domain. It can also be one of the write-side strobes, carried across the domains through a synchronizer, which adds latency and leaves the landing cycle uncertain by one read-clock cycle. Repeating strobes spaced at a multiple of eight cycles land on the positions the pointers already hold, so the stream is not disturbed. Clearing both select fields stops all realignment.

Top module: `strobe_aligned_fifo`

## Requirements
- R1: While its domain's reset is low at a clock edge, the write pointer is set to 0, the storage is cleared, the read pointer is loaded with `rd_offset`, all strobe history is cleared, and `rd_data` reads 0.
- R2: Without a pointer reset, each write-clock cycle stores `wr_data` at the write pointer and advances it by one. Each read-clock cycle registers the entry at the read pointer into `rd_data` and advances the read pointer. Both pointers wrap from 7 to 0.
- R3: The write-side trigger is a rising edge of a registered copy of a strobe enabled in `wr_sel`, where bit 0 enables `in_strobe` and bit 1 enables `sync_strobe`. On the cycle after the edge is seen, the write pointer is 0 instead of advancing.
- R4: A read-side trigger loads the read pointer with the current `rd_offset` instead of advancing it.
- R5: When `rd_sel` bit 2 is set, a rising edge of `out_strobe` is registered and edge-detected in the read domain and acts as a read-side trigger.
- R6: `rd_sel` bit 0 and bit 1 select the registered write-side copy of `in_strobe` or `sync_strobe`. That copy passes through a two-stage synchronizer and an edge detector in the read domain before it acts as a read-side trigger.
- R7: A strobe held high for many cycles yields exactly one trigger, at its rising edge.
- R8: When several select bits are set, their sources are ORed. Bit 3 of either field is reserved and has no effect, and bit 2 of `wr_sel` has no effect.
- R9: With both select fields at 0000, no strobe changes either pointer.
- R10: Strobes repeating every 8 cycles, once the pointers are aligned, leave the distance between the newest written sample and `rd_data` unchanged.
- R11: After realignment through the same path, that distance changes by exactly the change in `rd_offset`: a larger offset shortens it by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (input data) clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_data | input | DATA_W | Sample stored every write-clock cycle |
| in_strobe | input | 1 | Input strobe, write domain |
| sync_strobe | input | 1 | Sync strobe, write domain |
| wr_sel | input | SEL_W | Trigger source enables for the write pointer |
| rd_clk | input | 1 | Read (output sample) clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| out_strobe | input | 1 | Output strobe, read domain |
| rd_sel | input | SEL_W | Trigger source enables for the read pointer |
| rd_offset | input | log2(DEPTH) | Entry the read pointer is loaded with on a trigger |
| rd_data | output | DATA_W | Registered output sample |

## Verification
The stream is driven with a counting sample value. Under that stimulus, a wrong entry, a missed wrap or a stray pointer jump each shows up as a mismatch against a behavioural model, compared on every read cycle. The strobes are applied in several ways: isolated pulses at spacings that are not a multiple of eight, which move the pointers; long-held levels, which separate edge detection from level sensing; pulses on reserved or cleared select bits, which must leave the stream alone; and periodic pulses every eight cycles, which must not disturb it. Two aligned runs with different offsets check that the read lag follows the offset by exactly the difference. Such runs separate a correct offset load from one that is off by one entry or ignored.

// File: rtl/sfifo_pkg.sv
// Shared constants for the strobe-aligned sample FIFO.
// Assumes: select fields are at least three bits wide.
package sfifo_pkg;
    // Bit positions inside a source-select field
    localparam int SRC_IN   = 0;
    localparam int SRC_SYNC = 1;
    localparam int SRC_OUT  = 2;
    // Number of write-domain strobes that may cross to the read side
    localparam int NUM_WSRC = 2;
endpackage

// File: rtl/sfifo_sync2.sv
// Multi-stage level synchronizer into the destination clock.
// Assumes: the input is a registered level in another clock domain and
// STAGES >= 2.
module sfifo_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the foreign level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfifo_edge.sv
// Rising-edge detector for a level that is already registered in this clock.
// Assumes: lvl is a flop output of the same clock, so rise is glitch-free
// and lasts one cycle per low-to-high transition.
module sfifo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/sfifo_ptr.sv
// Ring pointer that advances every cycle and can be loaded with a value.
// Assumes: the ring depth is a power of two, so wrap is the natural
// overflow of the AW-bit count.
module sfifo_ptr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rst_val,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ptr
);
    // Reset to rst_val, load on trigger, otherwise step by one
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= rst_val;
        else if (load) ptr <= load_val;
        else           ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/strobe_aligned_fifo.sv
// Dual-clock sample ring whose pointers are placed by timing strobes.
// Write side stores one sample per cycle; read side presents one per cycle.
// Assumes: DEPTH is a power of two, SEL_W >= 3, and both strobe inputs on
// the write side are synchronous to wr_clk, out_strobe to rd_clk.
module strobe_aligned_fifo
    import sfifo_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst_n,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     in_strobe,
    input  logic                     sync_strobe,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     out_strobe,
    input  logic [SEL_W-1:0]         rd_sel,
    input  logic [$clog2(DEPTH)-1:0] rd_offset,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0]   mem [DEPTH];
    logic [NUM_WSRC-1:0] w_raw;
    logic [NUM_WSRC-1:0] w_lvl;
    logic [NUM_WSRC-1:0] w_rise;
    logic [NUM_WSRC-1:0] r_xlvl;
    logic [NUM_WSRC-1:0] r_xrise;
    logic                r_out_q;
    logic                r_out_rise;
    logic [SEL_W-1:0]    wr_src;
    logic [SEL_W-1:0]    rd_src;
    logic                wr_trig;
    logic                rd_trig;
    logic [AW-1:0]       wptr;
    logic [AW-1:0]       rptr;

    assign w_raw = {sync_strobe, in_strobe};

    // Register the write-side strobes; these levels also feed the crossing
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) w_lvl <= '0;
        else           w_lvl <= w_raw;
    end

    // Per write-side strobe: local edge detect plus crossing into read domain
    for (genvar g = 0; g < NUM_WSRC; g++) begin : g_wsrc
        sfifo_edge u_wedge (
            .clk   (wr_clk),
            .rst_n (wr_rst_n),
            .lvl   (w_lvl[g]),
            .rise  (w_rise[g])
        );

        sfifo_sync2 #(.STAGES(SYNC_STAGES)) u_xsync (
            .clk   (rd_clk),
            .rst_n (rd_rst_n),
            .d     (w_lvl[g]),
            .q     (r_xlvl[g])
        );

        sfifo_edge u_redge (
            .clk   (rd_clk),
            .rst_n (rd_rst_n),
            .lvl   (r_xlvl[g]),
            .rise  (r_xrise[g])
        );
    end

    // Register the local output strobe in the read domain
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) r_out_q <= 1'b0;
        else           r_out_q <= out_strobe;
    end

    sfifo_edge u_out_edge (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .lvl   (r_out_q),
        .rise  (r_out_rise)
    );

    // Map the available edges onto select-bit positions (others stay 0)
    always_comb begin
        wr_src           = '0;
        wr_src[SRC_IN]   = w_rise[SRC_IN];
        wr_src[SRC_SYNC] = w_rise[SRC_SYNC];
        rd_src           = '0;
        rd_src[SRC_IN]   = r_xrise[SRC_IN];
        rd_src[SRC_SYNC] = r_xrise[SRC_SYNC];
        rd_src[SRC_OUT]  = r_out_rise;
    end

    assign wr_trig = |(wr_sel & wr_src);
    assign rd_trig = |(rd_sel & rd_src);

    sfifo_ptr #(.AW(AW)) u_wptr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .rst_val  ('0),
        .load     (wr_trig),
        .load_val ('0),
        .ptr      (wptr)
    );

    sfifo_ptr #(.AW(AW)) u_rptr (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .rst_val  (rd_offset),
        .load     (rd_trig),
        .load_val (rd_offset),
        .ptr      (rptr)
    );

    // Store one sample per write cycle; clear the ring on write reset
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            mem[wptr] <= wr_data;
        end
    end

    // Register the entry under the read pointer
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) rd_data <= '0;
        else           rd_data <= mem[rptr];
    end
endmodule

// File: rtl/strobe_aligned_fifo_chk.sv
// Property checker for strobe_aligned_fifo, attached by bind.
// Assumes: pointer and trigger signals are those of the bound instance.
module strobe_aligned_fifo_chk #(
    parameter int AW = 3
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_trig,
    input logic          rd_trig,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] rptr,
    input logic [AW-1:0] rd_offset,
    input logic          w_in_rise,
    input logic          r_out_rise
);
    // R3: a write trigger puts the write pointer at entry 0
    p_wptr_zero_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_trig |=> (wptr == '0));

    // R2: without a trigger the write pointer steps by one, wrapping
    p_wptr_step_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_trig |=> (wptr == AW'($past(wptr) + 1'b1)));

    // R4: a read trigger loads the offset sampled with it
    p_rptr_load_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_trig |=> (rptr == $past(rd_offset)));

    // R2: without a trigger the read pointer steps by one, wrapping
    p_rptr_step_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_trig |=> (rptr == AW'($past(rptr) + 1'b1)));

    // R7: an input-strobe edge lasts a single write cycle
    p_in_edge_once_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        w_in_rise |=> !w_in_rise);

    // R7: an output-strobe edge lasts a single read cycle
    p_out_edge_once_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        r_out_rise |=> !r_out_rise);
endmodule

bind strobe_aligned_fifo strobe_aligned_fifo_chk #(.AW(AW)) u_chk (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .wr_trig    (wr_trig),
    .rd_trig    (rd_trig),
    .wptr       (wptr),
    .rptr       (rptr),
    .rd_offset  (rd_offset),
    .w_in_rise  (w_rise[0]),
    .r_out_rise (r_out_rise)
);

// File: tb/strobe_aligned_fifo_tb.sv
module strobe_aligned_fifo_tb;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          in_strobe = 1'b0;
    logic          sync_strobe = 1'b0;
    logic          out_strobe = 1'b0;
    logic [3:0]    wr_sel = 4'b0000;
    logic [3:0]    rd_sel = 4'b0000;
    logic [AW-1:0] rd_offset = 3'd4;
    logic [DW-1:0] rd_data;

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";
    bit    cmp_ok = 0;

    // Reference model state
    int mem_m [DEPTH];
    int wp_m = 0, rp_m = 0, exp_rd = 0, last_w = 0;
    bit li1, li2, ls1, ls2;
    bit ri1, ri2, ri3, rs1, rs2, rs3, lo1, lo2;

    strobe_aligned_fifo u_dut (
        .wr_clk      (wr_clk),
        .wr_rst_n    (rst_n),
        .wr_data     (wr_data),
        .in_strobe   (in_strobe),
        .sync_strobe (sync_strobe),
        .wr_sel      (wr_sel),
        .rd_clk      (rd_clk),
        .rd_rst_n    (rst_n),
        .out_strobe  (out_strobe),
        .rd_sel      (rd_sel),
        .rd_offset   (rd_offset),
        .rd_data     (rd_data)
    );

    // 125 MHz clocks; the read clock trails the write clock by 2 ns
    initial forever #4 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Counting sample stream
    always @(negedge wr_clk) if (rst_n) wr_data <= wr_data + 1'b1;

    // Write-side model
    always @(posedge wr_clk) begin
        if (!rst_n) begin
            foreach (mem_m[i]) mem_m[i] = 0;
            wp_m = 0; li1 = 0; li2 = 0; ls1 = 0; ls2 = 0;
        end else begin
            bit trig;
            trig = (wr_sel[0] && li1 && !li2) || (wr_sel[1] && ls1 && !ls2);
            mem_m[wp_m] = wr_data;
            last_w = wr_data;
            wp_m = trig ? 0 : (wp_m + 1) % DEPTH;
            li2 = li1; li1 = in_strobe;
            ls2 = ls1; ls1 = sync_strobe;
        end
    end

    // Read-side model
    always @(posedge rd_clk) begin
        if (!rst_n) begin
            exp_rd = 0; rp_m = rd_offset;
            ri1 = 0; ri2 = 0; ri3 = 0; rs1 = 0; rs2 = 0; rs3 = 0; lo1 = 0; lo2 = 0;
        end else begin
            bit trig;
            exp_rd = mem_m[rp_m];
            trig = (rd_sel[0] && ri2 && !ri3) || (rd_sel[1] && rs2 && !rs3)
                || (rd_sel[2] && lo1 && !lo2);
            rp_m = trig ? int'(rd_offset) : (rp_m + 1) % DEPTH;
            ri3 = ri2; ri2 = ri1; ri1 = li1;
            rs3 = rs2; rs2 = rs1; rs1 = ls1;
            lo2 = lo1; lo1 = out_strobe;
            cmp_ok = 1;
        end
    end

    // Per-cycle comparison, away from the read edge
    always @(negedge rd_clk) begin
        if (rst_n && cmp_ok)
            chk(rd_data == DW'(exp_rd), {cur_tag, " rd_data"}, rd_data, exp_rd);
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic pulse_in(input int width);
        @(negedge wr_clk) in_strobe = 1; wcyc(width); in_strobe = 0;
    endtask

    task automatic pulse_sync(input int width);
        @(negedge wr_clk) sync_strobe = 1; wcyc(width); sync_strobe = 0;
    endtask

    task automatic pulse_out(input int width);
        @(negedge wr_clk) out_strobe = 1; wcyc(width); out_strobe = 0;
    endtask

    task automatic sync_every8(input int periods);
        repeat (periods) begin
            pulse_sync(1);
            wcyc(6);
        end
    endtask

    task automatic measure_lag(input string tag, output int d0);
        int d;
        @(negedge rd_clk) d0 = last_w - int'(rd_data);
        repeat (15) begin
            @(negedge rd_clk) d = last_w - int'(rd_data);
            chk(d == d0, tag, d, d0);
        end
    endtask

    initial begin
        int d_a, d_b;
        rst_n = 0;
        wcyc(4);
        // R1: reset state
        chk(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
        rst_n = 1;

        // R2 R9: free running, strobes with selects cleared
        cur_tag = "R2 R9";
        wcyc(10);
        pulse_in(1); wcyc(3); pulse_sync(2); wcyc(5); pulse_out(1);
        wcyc(20);

        // R3 R5: input strobe moves write pointer, output strobe read pointer
        cur_tag = "R3 R5";
        wr_sel = 4'b0001; rd_sel = 4'b0100;
        pulse_in(1); wcyc(3); pulse_out(1); wcyc(10);
        rd_offset = 3'd6; pulse_out(1); wcyc(5); pulse_in(1); wcyc(12);
        wr_sel = 4'b0010; pulse_sync(1); wcyc(11);

        // R6 R4: synced write-side strobe drives the read pointer
        cur_tag = "R6 R4";
        wr_sel = 4'b0001; rd_sel = 4'b0001; rd_offset = 3'd3;
        pulse_in(1); wcyc(13);
        rd_sel = 4'b0010; rd_offset = 3'd5; pulse_sync(1); wcyc(9);

        // R7: long-held strobes trigger once
        cur_tag = "R7";
        wr_sel = 4'b0001; rd_sel = 4'b0001;
        pulse_in(21); wcyc(10);
        rd_sel = 4'b0100; pulse_out(19); wcyc(10);

        // R8: reserved and write-side bit 2 ignored, multiple bits ORed
        cur_tag = "R8";
        wr_sel = 4'b1100; rd_sel = 4'b1000;
        pulse_in(1); wcyc(2); pulse_sync(1); wcyc(2); pulse_out(1); wcyc(12);
        wr_sel = 4'b0011; rd_sel = 4'b0101; rd_offset = 3'd1;
        pulse_sync(1); wcyc(4); pulse_out(1); wcyc(6); pulse_in(1); wcyc(12);

        // R10 R11: periodic alignment, lag follows the offset
        cur_tag = "R10 R11";
        wr_sel = 4'b0010; rd_sel = 4'b0010; rd_offset = 3'd4;
        fork
            sync_every8(8);
            begin wcyc(32); measure_lag("R10 lag steady offset 4", d_a); end
        join
        rd_offset = 3'd6;
        fork
            sync_every8(8);
            begin wcyc(32); measure_lag("R10 lag steady offset 6", d_b); end
        join
        // R11: lag shrinks by the offset increase (6 - 4)
        chk(d_a - d_b == 2, "R11 lag difference", d_a - d_b, 2);

        // R9: cleared selects stop realignment
        cur_tag = "R9";
        wr_sel = 4'b0000; rd_sel = 4'b0000; rd_offset = 3'd0;
        pulse_sync(1); wcyc(3); pulse_in(1); pulse_out(1); wcyc(16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule